// File: doc/BRIEF.md
# Dual-Mode Indexed Sparse Scratchpad

This block is a small on-chip store for sparse vector elements, each keyed by an integer index rather than an address. A command port delivers one operation per cycle. Each command carries an opcode, four index lanes, four data lanes and a mode bit. With the mode bit low, the block works in direct-map mode: the low bits of each index pick a storage slot. With the mode bit high, it works in associative mode: each index is looked up in a tag table. A miss takes the next free slot, so elements are packed in the order they first appear.

Besides plain indexed stores and loads, the block does read-modify-write accumulation (add, subtract, multiply) against the stored element that matches each lane's index. This lets a vector unit merge sparse operands without gathers or software index matching. An element count tells software how many entries are live. A clear command empties the whole store in one cycle.

The tag table is split into banks of eight entries. A bank takes part in a lookup only once the element count reaches into it. Software is expected to keep to one mode between two clears.

Top module: `sspm_scratchpad`

## Requirements
- R1: After reset, elem_count is 0, overflow is 0 and resp_valid is 0.
- R2: In direct-map mode (cmd_mode=0) lane i uses slot cmd_idx[i*16+4 : i*16]. Indices that agree in their low 5 bits share one slot, and a store followed by a load of that slot returns the stored word.
- R3: In associative mode (cmd_mode=1) indices are matched on all 16 bits. A first-seen index takes slot number elem_count, and indices that agree only in their low bits stay separate elements.
- R4: A load (cmd_op=2) of an index that is not present returns 0 in that lane's resp_data word and sets resp_miss[i]. A present index returns its stored word with resp_miss[i]=0.
- R5: For a present index, add (3), subtract (4) and multiply (5) replace the stored word with stored+data, stored-data and the low 32 bits of stored*data. Store (1) replaces it with data.
- R6: An add, subtract or multiply to an absent index creates the element with data, the two's complement negation of data, or 0 respectively, and raises elem_count by one.
- R7: Lanes of one command are applied in ascending lane order. A lane whose index (or, in direct-map mode, slot) equals an earlier lane's sees that lane's result.
- R8: elem_count equals the number of live elements. A count command (6) returns it in lane 0 of resp_data, with the other lanes and resp_miss all 0.
- R9: A clear command (7) makes every element absent, sets elem_count to 0 and clears overflow.
- R10: In associative mode, an insert attempted with all 32 slots in use is dropped, leaves existing elements unchanged, and sets overflow. Overflow stays set until the next clear.
- R11: Loads and counts produce exactly one response with resp_valid high in the cycle after the command. No other command produces a response. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 store, 2 load, 3 add, 4 sub, 5 mul, 6 count, 7 clear |
| cmd_mode | input | 1 | 0 direct-map, 1 associative |
| cmd_idx | input | 64 | Four 16-bit indices, lane i at bits [16*i +: 16] |
| cmd_data | input | 128 | Four 32-bit operands, lane i at bits [32*i +: 32] |
| resp_valid | output | 1 | Response word valid |
| resp_data | output | 128 | Load results per lane, or the count in lane 0 |
| resp_miss | output | 4 | Per-lane miss flags of a load |
| elem_count | output | 6 | Number of live elements |
| overflow | output | 1 | Sticky dropped-insert flag |

## Verification
The assertions assume that software does not mix direct-map and associative commands between two clears. If it did, a direct write could land in a slot that associative allocation treats as free, and the count bound and monotonic-count checks would no longer hold. The stimulus keeps every segment between clears in a single mode. It drives the opcode only with cmd_valid high, and it waits for each response before judging the next count.

// File: rtl/sspm_pkg.sv
package sspm_pkg;
   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_STORE = 3'd1,
      OP_LOAD  = 3'd2,
      OP_ADD   = 3'd3,
      OP_SUB   = 3'd4,
      OP_MUL   = 3'd5,
      OP_COUNT = 3'd6,
      OP_CLEAR = 3'd7
   } sspm_op_e;
endpackage

// File: rtl/sspm_cam_bank.sv
module sspm_cam_bank #(
   parameter int IW    = 16,
   parameter int DEPTH = 8,
   parameter int BASE  = 0,
   parameter int CW    = 6,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic [DEPTH*IW-1:0] tags_i,
   input  logic [CW-1:0]       fill_i,
   input  logic [IW-1:0]       key_i,
   output logic                hit_o,
   output logic [PW-1:0]       pos_o
);
   logic bank_en;
   assign bank_en = int'(fill_i) > BASE;

   always_comb begin
      hit_o = 1'b0;
      pos_o = '0;
      if (bank_en) begin
         for (int e = 0; e < DEPTH; e++) begin
            if ((BASE + e) < int'(fill_i) && tags_i[e*IW +: IW] == key_i) begin
               hit_o = 1'b1;
               pos_o = PW'(e);
            end
         end
      end
   end
endmodule

// File: rtl/sspm_store.sv
module sspm_store #(
   parameter int LANES = 4,
   parameter int DW    = 32,
   parameter int IW    = 16,
   parameter int SLOTS = 32,
   localparam int SW   = $clog2(SLOTS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic [LANES-1:0]    wr_en_i,
   input  logic [LANES*SW-1:0] wr_slot_i,
   input  logic [LANES*DW-1:0] wr_val_i,
   input  logic [LANES-1:0]    tag_en_i,
   input  logic [LANES*IW-1:0] tag_i,
   output logic [SLOTS*DW-1:0] data_o,
   output logic [SLOTS-1:0]    valid_o,
   output logic [SLOTS*IW-1:0] tags_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= '0;
         tags_o  <= '0;
      end else if (clear_i) begin
         valid_o <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_en_i[l]) begin
               data_o[wr_slot_i[l*SW +: SW]*DW +: DW] <= wr_val_i[l*DW +: DW];
               valid_o[wr_slot_i[l*SW +: SW]]         <= 1'b1;
               if (tag_en_i[l])
                  tags_o[wr_slot_i[l*SW +: SW]*IW +: IW] <= tag_i[l*IW +: IW];
            end
         end
      end
   end

   AST_CLEAR_INVALID: assert property (@(posedge clk) disable iff (!rst_n) clear_i |=> valid_o == '0); // R9
endmodule

// File: rtl/sspm_scratchpad.sv
module sspm_scratchpad
   import sspm_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int DW         = 32,
   parameter int IW         = 16,
   parameter int SLOTS      = 32,
   parameter int BANK_DEPTH = 8,
   localparam int CW        = $clog2(SLOTS+1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [2:0]          cmd_op,
   input  logic                cmd_mode,
   input  logic [LANES*IW-1:0] cmd_idx,
   input  logic [LANES*DW-1:0] cmd_data,
   output logic                resp_valid,
   output logic [LANES*DW-1:0] resp_data,
   output logic [LANES-1:0]    resp_miss,
   output logic [CW-1:0]       elem_count,
   output logic                overflow
);
   localparam int SW    = $clog2(SLOTS);
   localparam int NBANK = SLOTS / BANK_DEPTH;
   localparam int BW    = $clog2(BANK_DEPTH);
   localparam int RDW   = LANES * DW;

   if (BANK_DEPTH < 2 || (1 << BW) != BANK_DEPTH) begin : g_bad_depth
      $error("BANK_DEPTH must be a power of two of at least 2");
   end
   if (SLOTS % BANK_DEPTH != 0 || (1 << SW) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two and a multiple of BANK_DEPTH");
   end
   if (IW < SW) begin : g_bad_iw
      $error("IW must cover the slot address");
   end

   sspm_op_e op;
   logic     is_wr, is_clr, is_load, is_cnt;
   assign op      = sspm_op_e'(cmd_op);
   assign is_wr   = cmd_valid && (op == OP_STORE || op == OP_ADD || op == OP_SUB || op == OP_MUL);
   assign is_clr  = cmd_valid && op == OP_CLEAR;
   assign is_load = cmd_valid && op == OP_LOAD;
   assign is_cnt  = cmd_valid && op == OP_COUNT;

   logic [SLOTS*DW-1:0] st_data;
   logic [SLOTS-1:0]    st_valid;
   logic [SLOTS*IW-1:0] st_tags;
   logic [CW-1:0]       count_q;
   logic                ovf_q;

   // associative lookup: one bank set per lane, banks gated by occupancy
   logic [LANES*NBANK-1:0]    bank_hit;
   logic [LANES*NBANK*BW-1:0] bank_pos;
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         sspm_cam_bank #(.IW(IW), .DEPTH(BANK_DEPTH), .BASE(b*BANK_DEPTH), .CW(CW)) u_bank (
            .tags_i (st_tags[b*BANK_DEPTH*IW +: BANK_DEPTH*IW]),
            .fill_i (count_q),
            .key_i  (cmd_idx[l*IW +: IW]),
            .hit_o  (bank_hit[l*NBANK + b]),
            .pos_o  (bank_pos[(l*NBANK + b)*BW +: BW])
         );
      end
   end

   function automatic logic [DW-1:0] lane_calc(sspm_op_e o, logic [DW-1:0] cur, logic [DW-1:0] opd);
      case (o)
         OP_ADD:  return cur + opd;
         OP_SUB:  return cur - opd;
         OP_MUL:  return cur * opd;
         default: return opd;
      endcase
   endfunction

   logic [IW-1:0]       l_idx  [LANES];
   logic [DW-1:0]       l_cur  [LANES];
   logic [DW-1:0]       l_res  [LANES];
   logic [SW-1:0]       l_slot [LANES];
   logic [SW-1:0]       c_slot [LANES];
   logic [LANES-1:0]    c_hit, l_present, l_new, l_place;
   logic [LANES*SW-1:0] wr_slot;
   logic [LANES*DW-1:0] wr_val;
   int                  nalloc;
   logic                ovf_set;

   // lane resolution in ascending order with forwarding between lanes
   always_comb begin
      nalloc    = 0;
      ovf_set   = 1'b0;
      c_hit     = '0;
      l_present = '0;
      l_new     = '0;
      l_place   = '0;
      for (int l = 0; l < LANES; l++) begin
         l_idx[l]  = cmd_idx[l*IW +: IW];
         l_slot[l] = '0;
         c_slot[l] = '0;
         l_cur[l]  = '0;
         l_res[l]  = '0;
         for (int b = 0; b < NBANK; b++) begin
            if (bank_hit[l*NBANK + b]) begin
               c_hit[l]  = 1'b1;
               c_slot[l] = SW'(b*BANK_DEPTH) + SW'(bank_pos[(l*NBANK + b)*BW +: BW]);
            end
         end
      end
      for (int l = 0; l < LANES; l++) begin
         if (cmd_mode) begin
            l_slot[l]    = c_slot[l];
            l_present[l] = c_hit[l];
            for (int j = 0; j < LANES; j++) begin
               if (j < l && l_place[j] && l_idx[j] == l_idx[l]) begin
                  l_present[l] = 1'b1;
                  l_slot[l]    = l_slot[j];
               end
            end
            if (!l_present[l] && is_wr) begin
               if (int'(count_q) + nalloc < SLOTS) begin
                  l_slot[l] = SW'(int'(count_q) + nalloc);
                  l_new[l]  = 1'b1;
                  nalloc    = nalloc + 1;
               end else begin
                  ovf_set = 1'b1;
               end
            end
         end else begin
            l_slot[l]    = l_idx[l][SW-1:0];
            l_present[l] = st_valid[l_slot[l]];
            for (int j = 0; j < LANES; j++) begin
               if (j < l && l_place[j] && l_slot[j] == l_slot[l])
                  l_present[l] = 1'b1;
            end
            if (!l_present[l] && is_wr) begin
               l_new[l] = 1'b1;
               nalloc   = nalloc + 1;
            end
         end
         l_place[l] = is_wr && (l_present[l] || l_new[l]);
         if (l_present[l]) begin
            l_cur[l] = st_data[l_slot[l]*DW +: DW];
            for (int j = 0; j < LANES; j++) begin
               if (j < l && l_place[j] && l_slot[j] == l_slot[l])
                  l_cur[l] = l_res[j];
            end
         end
         l_res[l] = lane_calc(op, l_cur[l], cmd_data[l*DW +: DW]);
      end
      for (int l = 0; l < LANES; l++) begin
         wr_slot[l*SW +: SW] = l_slot[l];
         wr_val[l*DW +: DW]  = l_res[l];
      end
   end

   sspm_store #(.LANES(LANES), .DW(DW), .IW(IW), .SLOTS(SLOTS)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (is_clr),
      .wr_en_i   (l_place),
      .wr_slot_i (wr_slot),
      .wr_val_i  (wr_val),
      .tag_en_i  (l_new & {LANES{cmd_mode}}),
      .tag_i     (cmd_idx),
      .data_o    (st_data),
      .valid_o   (st_valid),
      .tags_o    (st_tags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q    <= '0;
         ovf_q      <= 1'b0;
         resp_valid <= 1'b0;
         resp_data  <= '0;
         resp_miss  <= '0;
      end else begin
         resp_valid <= is_load || is_cnt;
         if (is_clr) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
         end else if (is_wr) begin
            count_q <= count_q + CW'(nalloc);
            ovf_q   <= ovf_q | ovf_set;
         end
         if (is_load) begin
            for (int l = 0; l < LANES; l++) begin
               resp_data[l*DW +: DW] <= l_cur[l];
               resp_miss[l]          <= !l_present[l];
            end
         end else if (is_cnt) begin
            resp_data <= RDW'(count_q);
            resp_miss <= '0;
         end
      end
   end

   assign elem_count = count_q;
   assign overflow   = ovf_q;

   AST_COUNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) int'(elem_count) <= SLOTS); // R8
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) is_clr |=> (elem_count == '0 && !overflow)); // R9
   AST_OVF_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) (overflow && !is_clr) |=> overflow); // R10
   AST_COUNT_GROWS:   assert property (@(posedge clk) disable iff (!rst_n) !is_clr |=> elem_count >= $past(elem_count)); // R6
   AST_RESP_AFTER:    assert property (@(posedge clk) disable iff (!rst_n) (is_load || is_cnt) |=> resp_valid); // R11
   AST_RESP_ONLY:     assert property (@(posedge clk) disable iff (!rst_n) !(is_load || is_cnt) |=> !resp_valid); // R11
endmodule

// File: tb/sspm_scratchpad_tb_top.sv
module sspm_scratchpad_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [2:0]   cmd_op = 3'd0;
   logic         cmd_mode = 1'b0;
   logic [63:0]  cmd_idx = '0;
   logic [127:0] cmd_data = '0;
   logic         resp_valid;
   logic [127:0] resp_data;
   logic [3:0]   resp_miss;
   logic [5:0]   elem_count;
   logic         overflow;

   always #5 clk = ~clk;

   sspm_scratchpad dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
      .cmd_idx(cmd_idx), .cmd_data(cmd_data), .resp_valid(resp_valid), .resp_data(resp_data),
      .resp_miss(resp_miss), .elem_count(elem_count), .overflow(overflow)
   );

   typedef struct {
      logic [127:0] d;
      logic [3:0]   m;
      string        rq;
   } exp_t;
   exp_t q[$];

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   // reference model built from the requirements
   int          mcnt = 0;
   bit          movf = 1'b0;
   logic [31:0] mval[32];
   bit          mvalid[32];
   logic [15:0] mtag[32];

   task automatic chk(bit ok, string rq, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic int find(bit cam, logic [15:0] ix);
      if (cam) begin
         for (int k = 0; k < mcnt; k++) if (mtag[k] == ix) return k;
         return -1;
      end
      return mvalid[ix[4:0]] ? int'(ix[4:0]) : -1;
   endfunction

   function automatic void mclear();
      mcnt = 0;
      movf = 1'b0;
      for (int k = 0; k < 32; k++) mvalid[k] = 1'b0;
   endfunction

   task automatic send(int op, bit cam, logic [15:0] i0, i1, i2, i3,
                       logic [31:0] d0, d1, d2, d3, string rq);
      logic [15:0] ix[4];
      logic [31:0] dx[4];
      exp_t        e;
      ix = '{i0, i1, i2, i3};
      dx = '{d0, d1, d2, d3};
      e.d = '0; e.m = '0; e.rq = rq;
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_mode = cam;
      cmd_idx  = {i3, i2, i1, i0};
      cmd_data = {d3, d2, d1, d0};
      for (int l = 0; l < 4; l++) begin
         int s;
         logic [31:0] cur;
         logic [31:0] nv;
         s = find(cam, ix[l]);
         if (op == 2) begin
            e.d[l*32 +: 32] = (s >= 0) ? mval[s] : 32'd0;
            e.m[l] = (s < 0);
         end else if (op >= 1 && op <= 5) begin
            cur = (s >= 0) ? mval[s] : 32'd0;
            case (op)
               3: nv = cur + dx[l];
               4: nv = cur - dx[l];
               5: nv = cur * dx[l];
               default: nv = dx[l];
            endcase
            if (s < 0) begin
               if (cam) begin
                  if (mcnt < 32) begin s = mcnt; mtag[s] = ix[l]; end
                  else movf = 1'b1;
               end else s = int'(ix[l][4:0]);
               if (s >= 0) begin mvalid[s] = 1'b1; mcnt++; end
            end
            if (s >= 0) mval[s] = nv;
         end
      end
      if (op == 6) e.d = 128'(mcnt);
      if (op == 7) mclear();
      if (op == 2 || op == 6) q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
      chk(elem_count == 6'(mcnt), {rq, " R8 elem_count"}, 128'(elem_count), 128'(mcnt));
      chk(overflow == movf, {rq, " R10 overflow"}, 128'(overflow), 128'(movf));
      if (op == 2 || op == 6)
         chk(resp_valid == 1'b1, {rq, " R11 response in next cycle"}, 128'(resp_valid), 128'd1);
   endtask

   // monitor: pops the expected response whenever the design offers one
   initial begin
      forever begin
         @(negedge clk);
         if (resp_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R11 unexpected response", 128'(resp_valid), 128'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(resp_data == e.d, {e.rq, " data"}, resp_data, e.d);
               chk(resp_miss == e.m, {e.rq, " miss"}, 128'(resp_miss), 128'(e.m));
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      mclear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(elem_count == 0, "R1 count after reset", 128'(elem_count), 128'd0);
      chk(overflow == 0, "R1 overflow after reset", 128'(overflow), 128'd0);
      chk(resp_valid == 0, "R1 resp_valid after reset", 128'(resp_valid), 128'd0);

      // direct-map: aliasing slots, ascending lane order
      send(1, 0, 16'd3, 16'd7, 16'd35, 16'd9, 32'h11, 32'h22, 32'h33, 32'h44, "R2 R7 direct store");
      send(2, 0, 16'd3, 16'd7, 16'd8, 16'd41, 0, 0, 0, 0, "R2 R4 direct load");
      send(0, 0, 16'd8, 16'd8, 16'd8, 16'd8, 32'h5, 32'h5, 32'h5, 32'h5, "R11 nop");
      send(3, 0, 16'd7, 16'd8, 16'd7, 16'd12, 32'h10, 32'h6, 32'h1, 32'h2, "R5 R6 R7 direct add");
      send(4, 0, 16'd9, 16'd13, 16'd3, 16'd3, 32'h4, 32'h9, 32'h3, 32'h3, "R5 R6 direct sub");
      send(5, 0, 16'd12, 16'd14, 16'd9, 16'd12, 32'h3, 32'h7, 32'h100, 32'h5, "R5 R6 direct mul");
      send(2, 0, 16'd7, 16'd8, 16'd13, 16'd14, 0, 0, 0, 0, "R5 R6 direct readback");
      send(2, 0, 16'd12, 16'd9, 16'd3, 16'd1, 0, 0, 0, 0, "R5 R7 direct readback");
      send(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 count");
      send(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 clear");
      send(2, 0, 16'd3, 16'd7, 16'd8, 16'd12, 0, 0, 0, 0, "R9 R4 load after clear");

      // associative mode
      send(1, 1, 16'd100, 16'd200, 16'd132, 16'd4, 32'hA, 32'hB, 32'hC, 32'hD, "R3 cam store");
      send(2, 1, 16'd132, 16'd4, 16'd36, 16'd100, 0, 0, 0, 0, "R3 R4 cam load");
      send(3, 1, 16'd100, 16'd100, 16'd500, 16'd100, 32'h1, 32'h2, 32'h3, 32'h4, "R5 R6 R7 cam add");
      send(4, 1, 16'd600, 16'd200, 16'd600, 16'd4, 32'h7, 32'h1, 32'h2, 32'hD, "R5 R6 R7 cam sub");
      send(5, 1, 16'd700, 16'd132, 16'd132, 16'd500, 32'h9, 32'h3, 32'h2, 32'h10000, "R5 R6 R7 cam mul");
      send(2, 1, 16'd100, 16'd500, 16'd600, 16'd200, 0, 0, 0, 0, "R5 R6 cam readback");
      send(2, 1, 16'd4, 16'd700, 16'd132, 16'd5, 0, 0, 0, 0, "R5 R6 cam readback");
      send(6, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 cam count");

      // fill all slots and overflow
      send(7, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 clear before fill");
      for (int k = 0; k < 9; k++) begin
         logic [15:0] b;
         b = 16'(1000 + 4*k);
         send(1, 1, b, b + 16'd1, b + 16'd2, b + 16'd3,
              32'(k*4), 32'(k*4+1), 32'(k*4+2), 32'(k*4+3), "R10 R3 fill");
      end
      send(2, 1, 16'd1000, 16'd1031, 16'd1032, 16'd1035, 0, 0, 0, 0, "R10 load after overflow");
      send(3, 1, 16'd1001, 16'd2000, 16'd1001, 16'd1030, 32'h5, 32'h5, 32'h5, 32'h5, "R10 R7 add when full");
      send(2, 1, 16'd1001, 16'd2000, 16'd1030, 16'd1029, 0, 0, 0, 0, "R10 readback when full");
      send(6, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 count when full");
      send(7, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 clear drops overflow");
      send(2, 1, 16'd1000, 16'd1001, 16'd1002, 16'd1003, 0, 0, 0, 0, "R9 load after clear");

      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R11 all responses seen", 128'(q.size()), 128'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule